// File: doc/BRIEF.md
# Barrier-Aware Hybrid Write Scheduler

This block sits in a memory controller in front of a multi-bank non-volatile memory whose frames serve two roles at once: scratch working memory and durable persistent store. A class map with one bit per frame tells the two apart. A set bit marks a working-memory frame. A clear bit marks a persistent frame. Software changes single bits through a small write port.

Write requests and ordering barriers enter an eight-entry queue with valid/ready flow control. Each cycle the scheduler may send one queued write to a bank that is not busy, so writes to different banks overlap in flight. A barrier orders only persistent writes: a persistent write queued behind a barrier waits until every persistent write ahead of the barrier has finished in its bank. Working-memory writes pass barriers freely. While a barrier is waiting, eligible persistent writes are chosen ahead of working ones. A write's class comes from the map at the moment it is scheduled. After a write issues, its bank stays busy for a programmable number of cycles.

Top module: `hws_write_sched`

## Requirements
- R1: After reset the class map is all clear, so every frame is persistent. The queue is empty, `reqReady` is 1, and `issueValid` and `barrierPending` are 0.
- R2: The frame index is `addr[ADDR_W-1:OFF_W]` and the bank is the low `BANK_W` bits of the frame index. `issueBank` carries that bank for every issued write.
- R3: When `mapWrEn` is 1, bit `mapFrame` of the class map takes `mapSet` (1 means working memory, 0 means persistent). The new value applies from the next cycle on, and `issuePersist` reports the class that applied when the write was scheduled.
- R4: A working-memory write can issue even when a barrier is queued ahead of it.
- R5: A persistent write behind a barrier issues no earlier than `busyCycles` cycles after the last persistent write ahead of that barrier issued.
- R6: While a barrier is pending, an eligible persistent write wins the issue slot over an older eligible working-memory write.
- R7: Among eligible writes of equal priority, the oldest issues first. With no barrier pending, writes are chosen in age order only.
- R8: A write issues only to an idle bank. After an issue, that bank stays busy for `busyCycles` cycles, so two writes to the same bank issue at least `busyCycles` cycles apart.
- R9: At most one write issues per cycle. Writes to different idle banks can issue on consecutive cycles, so several are in flight together.
- R10: `barrierPending` is 1 while any barrier is queued. A barrier retires, and the indication clears, once all persistent writes ahead of it have completed.
- R11: The queue holds 8 entries. `reqReady` is 0 while it is full, and a request is taken only in a cycle where `reqValid` and `reqReady` are both 1.
- R12: For each scheduled write, `issueValid` pulses for one cycle, with the queued address on `issueAddr` and the queued data on `issueData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Queue can accept a request |
| reqIsBarrier | input | 1 | Request is a barrier, not a write |
| reqAddr | input | ADDR_W | Write address |
| reqData | input | DATA_W | Write data |
| mapWrEn | input | 1 | Class map update strobe |
| mapFrame | input | ADDR_W-OFF_W | Frame index to update |
| mapSet | input | 1 | New class bit (1 working, 0 persistent) |
| busyCycles | input | LAT_W | Bank busy time per write, in cycles |
| issueValid | output | 1 | Write issued this cycle |
| issueAddr | output | ADDR_W | Issued address |
| issueData | output | DATA_W | Issued data |
| issueBank | output | BANK_W | Bank of the issued write |
| issuePersist | output | 1 | Issued write was classed persistent |
| barrierPending | output | 1 | At least one barrier is queued |

## Verification
Two functions can contend in one cycle: a bank freeing up with both a persistent write and an older working write waiting for it, and the age rule that would otherwise choose the working write. The bench holds one bank busy with a working write, then queues a working write, a persistent write and a barrier, all aimed at that bank. The scoreboard must see the persistent write issue first. The same sequence is then run without the barrier, and the age order must return. A second overlap, a barrier retiring in the same cycle that a bank finishes its last persistent write, is judged by when the persistent write behind the barrier issues, measured against the completion time.

// File: rtl/hws_pkg.sv
`timescale 1ns/1ps
package hws_pkg;
  localparam int Q_DEPTH = 8;
  localparam int QIDX_W  = $clog2(Q_DEPTH);
  localparam int QCNT_W  = QIDX_W + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic              push;
    logic              issueHit;
    logic [QIDX_W-1:0] issueIdx;
    logic              retireHit;
    logic [QIDX_W-1:0] retireIdx;
  } hws_ctl_t;
endpackage

// File: rtl/hws_datapath.sv
`timescale 1ns/1ps
module hws_datapath
  import hws_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 4,
  parameter int NUM_BANKS = 4,
  parameter int LAT_W     = 5,
  localparam int FRAME_W  = ADDR_W - OFF_W,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  hws_ctl_t                       ctl,
  input  logic                           reqIsBarrier,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [DATA_W-1:0]              reqData,
  input  logic                           mapWrEn,
  input  logic [FRAME_W-1:0]             mapFrame,
  input  logic                           mapSet,
  input  logic [LAT_W-1:0]               busyCycles,
  output logic [Q_DEPTH-1:0]             qValid,
  output logic [Q_DEPTH-1:0]             qBarrier,
  output logic [Q_DEPTH-1:0]             qPersist,
  output logic [Q_DEPTH-1:0][BANK_W-1:0] qBank,
  output logic [NUM_BANKS-1:0]           bankIdle,
  output logic [NUM_BANKS-1:0]           bankPersistBusy,
  output logic                           issueValid,
  output logic [ADDR_W-1:0]              issueAddr,
  output logic [DATA_W-1:0]              issueData,
  output logic [BANK_W-1:0]              issueBank,
  output logic                           issuePersist
);
  localparam int NUM_FRAMES = 1 << FRAME_W;

  logic [NUM_FRAMES-1:0]             classMap;
  logic [Q_DEPTH-1:0][ADDR_W-1:0]    entAddr, nAddr;
  logic [Q_DEPTH-1:0][DATA_W-1:0]    entData, nData;
  logic [Q_DEPTH-1:0]                entBar, nBar;
  logic [QCNT_W-1:0]                 count, nCount;
  logic [NUM_BANKS-1:0]              bankLoad;
  logic [BANK_W-1:0]                 selBank;
  logic [LAT_W-1:0]                  loadLat;

  // class map, software port
  always_ff @(posedge clk) begin
    if (!rstN) classMap <= '0;
    else if (mapWrEn) classMap[mapFrame] <= mapSet;
  end

  // per-entry view for control
  for (genvar i = 0; i < Q_DEPTH; i++) begin : g_view
    assign qValid[i]   = QCNT_W'(i) < count;
    assign qBarrier[i] = entBar[i];
    assign qBank[i]    = entAddr[i][OFF_W +: BANK_W];
    assign qPersist[i] = ~classMap[entAddr[i][ADDR_W-1:OFF_W]];
  end

  // collapsing queue: drop issued/retired entries, append new request
  always_comb begin
    logic [QCNT_W-1:0] wp;
    logic keep;
    nAddr = entAddr;
    nData = entData;
    nBar  = entBar;
    wp    = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      keep = (QCNT_W'(i) < count)
           && !(ctl.issueHit  && ctl.issueIdx  == QIDX_W'(i))
           && !(ctl.retireHit && ctl.retireIdx == QIDX_W'(i));
      if (keep) begin
        nAddr[wp[QIDX_W-1:0]] = entAddr[i];
        nData[wp[QIDX_W-1:0]] = entData[i];
        nBar[wp[QIDX_W-1:0]]  = entBar[i];
        wp = wp + QCNT_W'(1);
      end
    end
    if (ctl.push) begin
      nAddr[wp[QIDX_W-1:0]] = reqAddr;
      nData[wp[QIDX_W-1:0]] = reqData;
      nBar[wp[QIDX_W-1:0]]  = reqIsBarrier;
      wp = wp + QCNT_W'(1);
    end
    nCount = wp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      entAddr <= '0;
      entData <= '0;
      entBar  <= '0;
    end else begin
      count   <= nCount;
      entAddr <= nAddr;
      entData <= nData;
      entBar  <= nBar;
    end
  end

  // bank busy tracking
  assign selBank = entAddr[ctl.issueIdx][OFF_W +: BANK_W];
  assign loadLat = (busyCycles == '0) ? LAT_W'(1) : busyCycles;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LAT_W-1:0] busyCnt;
    logic             persistFlag;
    assign bankLoad[b] = ctl.issueHit && (selBank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyCnt     <= '0;
        persistFlag <= 1'b0;
      end else if (bankLoad[b]) begin
        busyCnt     <= loadLat;
        persistFlag <= qPersist[ctl.issueIdx];
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - LAT_W'(1);
      end
    end
    assign bankIdle[b]        = (busyCnt == '0);
    assign bankPersistBusy[b] = (busyCnt != '0) && persistFlag;
  end

  // issue register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueValid   <= 1'b0;
      issueAddr    <= '0;
      issueData    <= '0;
      issueBank    <= '0;
      issuePersist <= 1'b0;
    end else begin
      issueValid <= ctl.issueHit;
      if (ctl.issueHit) begin
        issueAddr    <= entAddr[ctl.issueIdx];
        issueData    <= entData[ctl.issueIdx];
        issueBank    <= selBank;
        issuePersist <= qPersist[ctl.issueIdx];
      end
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (count < QCNT_W'(Q_DEPTH)));
  // R8
  bank_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueHit |-> bankIdle[selBank]);
  // R12
  issue_is_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueHit |-> ((QCNT_W'(ctl.issueIdx) < count) && !entBar[ctl.issueIdx]));
  // R10
  retire_is_barrier_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.retireHit |-> ((QCNT_W'(ctl.retireIdx) < count) && entBar[ctl.retireIdx]
                       && !(|bankPersistBusy)));
endmodule

// File: rtl/hws_control.sv
`timescale 1ns/1ps
module hws_control
  import hws_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic [Q_DEPTH-1:0]             qValid,
  input  logic [Q_DEPTH-1:0]             qBarrier,
  input  logic [Q_DEPTH-1:0]             qPersist,
  input  logic [Q_DEPTH-1:0][BANK_W-1:0] qBank,
  input  logic [NUM_BANKS-1:0]           bankIdle,
  input  logic [NUM_BANKS-1:0]           bankPersistBusy,
  output hws_ctl_t                       ctl,
  output logic                           reqReady,
  output logic                           barrierPending
);
  logic [Q_DEPTH-1:0] elig;
  logic               pHit, aHit, barFound, olderPersist;
  logic [QIDX_W-1:0]  pIdx, aIdx, barIdx;

  assign reqReady       = ~qValid[Q_DEPTH-1];
  assign barrierPending = |(qValid & qBarrier);

  // eligibility: idle bank; persistent writes must have no barrier ahead
  always_comb begin
    logic seenBar;
    seenBar = 1'b0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      elig[i] = qValid[i] && !qBarrier[i] && bankIdle[qBank[i]]
              && (!qPersist[i] || !seenBar);
      if (qValid[i] && qBarrier[i]) seenBar = 1'b1;
    end
  end

  // oldest eligible overall and oldest eligible persistent
  always_comb begin
    pHit = 1'b0; pIdx = '0;
    aHit = 1'b0; aIdx = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (elig[i] && !aHit) begin
        aHit = 1'b1;
        aIdx = QIDX_W'(i);
      end
      if (elig[i] && qPersist[i] && !pHit) begin
        pHit = 1'b1;
        pIdx = QIDX_W'(i);
      end
    end
  end

  // oldest barrier and whether persistent writes still sit ahead of it
  always_comb begin
    barFound     = 1'b0;
    barIdx       = '0;
    olderPersist = 1'b0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (!barFound && qValid[i]) begin
        if (qBarrier[i]) begin
          barFound = 1'b1;
          barIdx   = QIDX_W'(i);
        end else if (qPersist[i]) begin
          olderPersist = 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.push      = reqValid && reqReady;
    ctl.issueHit  = aHit;
    ctl.issueIdx  = (barrierPending && pHit) ? pIdx : aIdx;
    ctl.retireHit = barFound && !olderPersist && !(|bankPersistBusy);
    ctl.retireIdx = barIdx;
  end

  // R6
  persist_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issueHit && barrierPending && pHit) |-> qPersist[ctl.issueIdx]);
endmodule

// File: rtl/hws_write_sched.sv
`timescale 1ns/1ps
module hws_write_sched
  import hws_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 4,
  parameter int NUM_BANKS = 4,
  parameter int LAT_W     = 5,
  localparam int FRAME_W  = ADDR_W - OFF_W,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqIsBarrier,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  input  logic               mapWrEn,
  input  logic [FRAME_W-1:0] mapFrame,
  input  logic               mapSet,
  input  logic [LAT_W-1:0]   busyCycles,
  output logic               issueValid,
  output logic [ADDR_W-1:0]  issueAddr,
  output logic [DATA_W-1:0]  issueData,
  output logic [BANK_W-1:0]  issueBank,
  output logic               issuePersist,
  output logic               barrierPending
);
  hws_ctl_t                       ctl;
  logic [Q_DEPTH-1:0]             qValid, qBarrier, qPersist;
  logic [Q_DEPTH-1:0][BANK_W-1:0] qBank;
  logic [NUM_BANKS-1:0]           bankIdle, bankPersistBusy;

  hws_control #(.NUM_BANKS(NUM_BANKS)) i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .qValid(qValid), .qBarrier(qBarrier), .qPersist(qPersist), .qBank(qBank),
    .bankIdle(bankIdle), .bankPersistBusy(bankPersistBusy),
    .ctl(ctl), .reqReady(reqReady), .barrierPending(barrierPending)
  );

  hws_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
    .NUM_BANKS(NUM_BANKS), .LAT_W(LAT_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqIsBarrier(reqIsBarrier), .reqAddr(reqAddr), .reqData(reqData),
    .mapWrEn(mapWrEn), .mapFrame(mapFrame), .mapSet(mapSet),
    .busyCycles(busyCycles),
    .qValid(qValid), .qBarrier(qBarrier), .qPersist(qPersist), .qBank(qBank),
    .bankIdle(bankIdle), .bankPersistBusy(bankPersistBusy),
    .issueValid(issueValid), .issueAddr(issueAddr), .issueData(issueData),
    .issueBank(issueBank), .issuePersist(issuePersist)
  );

  // R2
  bank_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (issueBank == issueAddr[OFF_W +: BANK_W]));
endmodule

// File: tb/test_hws_write_sched.sv
`timescale 1ns/1ps
module test_hws_write_sched;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 4;
  localparam int BANK_W = 2;
  localparam int LAT_W  = 5;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              persist;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqIsBarrier = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic mapWrEn = 1'b0, mapSet = 1'b0;
  logic [ADDR_W-OFF_W-1:0] mapFrame = '0;
  logic [LAT_W-1:0] busyCycles = LAT_W'(8);
  logic issueValid, issuePersist, barrierPending;
  logic [ADDR_W-1:0] issueAddr;
  logic [DATA_W-1:0] issueData;
  logic [BANK_W-1:0] issueBank;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 1'b0;
  exp_t expQ[$];
  int issueCyc[int];

  always #2.5 clk = ~clk;

  hws_write_sched i_hws_write_sched (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsBarrier(reqIsBarrier), .reqAddr(reqAddr), .reqData(reqData),
    .mapWrEn(mapWrEn), .mapFrame(mapFrame), .mapSet(mapSet),
    .busyCycles(busyCycles), .issueValid(issueValid), .issueAddr(issueAddr),
    .issueData(issueData), .issueBank(issueBank), .issuePersist(issuePersist),
    .barrierPending(barrierPending)
  );

  function automatic logic [DATA_W-1:0] dataOf(logic [ADDR_W-1:0] a);
    return 32'hC0DE_0000 ^ {22'd0, a};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic expectIssue(int frame, bit persist);
    exp_t e;
    e.addr = ADDR_W'(frame << OFF_W);
    e.persist = persist;
    expQ.push_back(e);
  endtask

  task automatic pushReq(bit bar, int frame);
    @(negedge clk);
    reqValid = 1'b1;
    reqIsBarrier = bar;
    reqAddr = ADDR_W'(frame << OFF_W);
    reqData = dataOf(ADDR_W'(frame << OFF_W));
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic setMap(int frame, bit val);
    @(negedge clk);
    mapWrEn = 1'b1;
    mapFrame = (ADDR_W-OFF_W)'(frame);
    mapSet = val;
    @(negedge clk);
    mapWrEn = 1'b0;
  endtask

  task automatic setLat(int lat);
    @(negedge clk);
    busyCycles = LAT_W'(lat);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  function automatic int cycOf(int frame);
    int a = frame << OFF_W;
    if (issueCyc.exists(a)) return issueCyc[a];
    return -100000;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (rstN && issueValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected issue", issueAddr, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(issueAddr == e.addr, "R7 issue order addr", issueAddr, e.addr);
        chk(issuePersist == e.persist, "R3 class at issue", issuePersist, e.persist);
        chk(issueBank == e.addr[OFF_W +: BANK_W], "R2 bank", issueBank, e.addr[OFF_W +: BANK_W]);
        chk(issueData == dataOf(e.addr), "R12 data", issueData, dataOf(e.addr));
        issueCyc[int'(issueAddr)] = cyc;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int fr[10];
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    chk(issueValid == 1'b0, "R1 issueValid", issueValid, 0);
    chk(barrierPending == 1'b0, "R1 barrierPending", barrierPending, 0);

    // R9: four banks back to back, all persistent after reset (R1)
    for (int f = 20; f < 24; f++) expectIssue(f, 1'b1);
    for (int f = 20; f < 24; f++) pushReq(1'b0, f);
    drain();
    for (int f = 21; f < 24; f++)
      chk(cycOf(f) - cycOf(f - 1) == 1, "R9 consecutive issue", cycOf(f) - cycOf(f - 1), 1);

    // R3: mark working frames
    setMap(6, 1'b1); setMap(8, 1'b1); setMap(12, 1'b1);
    setMap(24, 1'b1); setMap(28, 1'b1);

    // R4 / R5 / R10: barrier with a working write bypassing it
    setLat(10);
    expectIssue(0, 1'b1); expectIssue(6, 1'b0); expectIssue(5, 1'b1);
    pushReq(1'b0, 0); pushReq(1'b1, 0); pushReq(1'b0, 5); pushReq(1'b0, 6);
    @(negedge clk);
    chk(barrierPending == 1'b1, "R10 pending while barrier queued", barrierPending, 1);
    drain();
    chk(barrierPending == 1'b0, "R10 pending clears after retire", barrierPending, 0);
    chk(cycOf(5) - cycOf(0) >= 10, "R5 barrier wait", cycOf(5) - cycOf(0), 10);
    chk(cycOf(6) < cycOf(5), "R4 working bypasses barrier", cycOf(6), cycOf(5));

    // R6: same-slot contest with barrier pending
    expectIssue(8, 1'b0); expectIssue(16, 1'b1); expectIssue(12, 1'b0);
    pushReq(1'b0, 8); pushReq(1'b0, 12); pushReq(1'b0, 16); pushReq(1'b1, 0);
    drain();
    chk(cycOf(16) < cycOf(12), "R6 persistent beats older working", cycOf(16), cycOf(12));

    // R7: same contest without barrier, age wins
    expectIssue(24, 1'b0); expectIssue(28, 1'b0); expectIssue(32, 1'b1);
    pushReq(1'b0, 24); pushReq(1'b0, 28); pushReq(1'b0, 32);
    drain();
    chk(cycOf(28) < cycOf(32), "R7 age order without barrier", cycOf(28), cycOf(32));

    // R3: clear frame 6, it now obeys barriers
    setMap(6, 1'b0);
    expectIssue(1, 1'b1); expectIssue(8, 1'b0); expectIssue(6, 1'b1);
    pushReq(1'b0, 1); pushReq(1'b1, 0); pushReq(1'b0, 6); pushReq(1'b0, 8);
    drain();
    chk(cycOf(6) - cycOf(1) >= 10, "R3 cleared frame waits on barrier", cycOf(6) - cycOf(1), 10);

    // R11 / R8: fill the queue behind one busy bank
    setLat(30);
    fr = '{36, 40, 44, 48, 52, 56, 60, 0, 4, 16};
    foreach (fr[k]) expectIssue(fr[k], 1'b1);
    for (int k = 0; k < 9; k++) pushReq(1'b0, fr[k]);
    @(negedge clk);
    chk(reqReady == 1'b0, "R11 full queue stalls", reqReady, 0);
    pushReq(1'b0, fr[9]);
    drain();
    for (int k = 1; k < 10; k++)
      chk(cycOf(fr[k]) - cycOf(fr[k - 1]) >= 30, "R8 same bank spacing",
          cycOf(fr[k]) - cycOf(fr[k - 1]), 30);
    chk(reqReady == 1'b1, "R11 ready after drain", reqReady, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule